// File: doc/BRIEF.md
# Multi-Mode Timer Channel

This block is one channel attached to a shared free-running counter. The counter value, its wrap strobe and its modulo limit come in from outside. Software programs the channel through two registers. The first is an 8-bit status/control byte that holds the event flag, the interrupt enable, a 2-bit mode select and a 2-bit edge/level select. The second is a 16-bit channel value register.

The mode and edge/level fields pick what the channel does:
- It can be switched off, which returns the pin to general-purpose I/O.
- It can time-stamp edges on an input pin.
- It can drive a pin level when the counter reaches the channel value.
- It can generate edge-aligned PWM.

Every capture or compare event sets a sticky flag, and that flag can raise an interrupt. Software clears the flag in two steps: it reads the status byte while the flag is set, then writes 0 to the flag bit. An event that arrives between those two accesses keeps the flag set, so no event is lost. In PWM mode the flag is not set at 0% or 100% duty.

Top module: `tmr_chan`

## Requirements
- R1: The status byte reads as {flag[7], irq_en[6], mode_sel[5:4], edge_sel[3:2], 2'b00}. A write stores bits 6..2 and ignores bit 7 and bits 1..0. The value register reads back what was last written to it, unless a capture has overwritten it since.
- R2: When edge_sel is 00, the channel is off whatever mode_sel holds. In that state pin_oe is 0 and no event sets the flag.
- R3: With mode_sel 00 and edge_sel not 00, the channel captures. Edge_sel 01 selects rising edges, 10 selects falling edges and 11 selects both. The pin passes through a two-flop synchronizer, so a change driven before clock edge k sets the flag and loads cnt_val into the value register at edge k+2.
- R4: With mode_sel 01, a cycle in which cnt_val equals the channel value sets the flag. At the next edge that cycle also acts on pin_out: edge_sel 01 toggles it, 10 clears it and 11 sets it. In cycles without a match the pin holds.
- R5: With mode_sel[1] set, the channel runs edge-aligned PWM. The active level is high for edge_sel 10 and low for edge_sel X1. A cycle with cnt_ovf drives pin_out to the active level at the next edge. A match drives it to the inactive level. When both happen in one cycle, the overflow wins.
- R6: In PWM mode, a channel value of 0 holds pin_out inactive and a channel value above cnt_mod holds it active. In both cases no match sets the flag.
- R7: irq is 1 exactly when both the flag and irq_en are 1.
- R8: The flag clears only on a status write with bit 7 = 0 that follows an arming read, which is a status read taken while the flag is 1. A status write with bit 7 = 1 leaves the flag unchanged.
- R9: An event that occurs after the arming read and before the clearing write cancels the clear, so the flag stays 1.
- R10: Any status write disarms a pending clear. A status read taken while the flag is 0 also disarms it.
- R11: Reset (synchronous, active high) zeroes the control fields, the flag, the value register and pin_out. It leaves pin_oe and irq at 0.
- R12: pin_oe is 1 in compare and PWM modes and 0 in capture and off modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | Counter wrap strobe, high in the last count of a period |
| cnt_mod | input | CNT_W | Counter modulo limit |
| pin_in | input | 1 | Asynchronous capture pin |
| csr_rd | input | 1 | Status byte read strobe |
| csr_wr | input | 1 | Status byte write strobe |
| csr_wdata | input | 8 | Status byte write data |
| csr_rdata | output | 8 | Status byte read data |
| val_wr | input | 1 | Channel value write strobe |
| val_wdata | input | CNT_W | Channel value write data |
| val_rdata | output | CNT_W | Channel value read data |
| pin_out | output | 1 | Driven pin level |
| pin_oe | output | 1 | Pin owned by the channel when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- A capture edge loads the counter into the value register.
- The flag only falls after a status write with bit 7 clear that was preceded by an arming read.
- Any event sets the flag on the next edge.
- An off channel never raises the flag.
- PWM at 0% or 100% neither sets the flag nor leaves the inactive or active level.
- A compare pin holds between matches.

Only the bench scenarios can show the rest:
- The exact toggle, clear and set actions on a match.
- The two-cycle synchronizer latency.
- Which edge polarities are ignored.
- That a write disarms the clear.
- That overflow beats a same-cycle match.
- The full decode of the status byte.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        CH_OFF,
        CH_CAPTURE,
        CH_COMPARE,
        CH_PWM
    } ch_mode_e;

    typedef struct packed {
        logic       irq_en;
        logic [1:0] mode_sel;
        logic [1:0] edge_sel;
    } ch_ctrl_t;

    localparam int FLAG_BIT = 7;

    // edge_sel 00 parks the pin regardless of mode bits
    function automatic ch_mode_e decode_mode(ch_ctrl_t c);
        if (c.edge_sel == 2'b00) return CH_OFF;
        if (c.mode_sel[1])       return CH_PWM;
        if (c.mode_sel[0])       return CH_COMPARE;
        return CH_CAPTURE;
    endfunction

    function automatic ch_ctrl_t unpack_ctrl(logic [7:0] b);
        ch_ctrl_t c;
        c.irq_en   = b[6];
        c.mode_sel = b[5:4];
        c.edge_sel = b[3:2];
        return c;
    endfunction

    function automatic logic [7:0] pack_status(logic flag, ch_ctrl_t c);
        return {flag, c.irq_en, c.mode_sel, c.edge_sel, 2'b00};
    endfunction

    // PWM active level: high-true only for edge_sel 10
    function automatic logic pwm_active_level(logic [1:0] es);
        return (es == 2'b10);
    endfunction

endpackage

// File: rtl/tmr_chan_edge.sv
module tmr_chan_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    input  logic       enable,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   synced;
    logic                   rise;
    logic                   fall;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            prev_q <= synced;
        end
    end

    assign rise = synced & ~prev_q;
    assign fall = ~synced & prev_q;
    assign hit  = enable & ((edge_sel[0] & rise) | (edge_sel[1] & fall));

    // R3: a single transition produces a one-cycle hit
    p_hit_single_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic st_rd,
    input  logic st_wr,
    input  logic wr_flag_bit,
    output logic flag
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (evt)
                flag <= 1'b1;
            else if (st_wr && armed_q && !wr_flag_bit)
                flag <= 1'b0;

            if (evt || st_wr)
                armed_q <= 1'b0;
            else if (st_rd)
                armed_q <= flag;
        end
    end

    p_event_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag);

    p_clear_by_zero_write_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(st_wr && !wr_flag_bit));

    p_clear_needs_arm_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(armed_q));

endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ch_mode_e   mode,
    input  logic [1:0] edge_sel,
    input  logic       match,
    input  logic       ovf,
    input  logic       duty0,
    input  logic       duty100,
    output logic       pin_q
);
    logic active;

    assign active = pwm_active_level(edge_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            unique case (mode)
                CH_COMPARE: begin
                    if (match) begin
                        unique case (edge_sel)
                            2'b01:   pin_q <= ~pin_q;
                            2'b10:   pin_q <= 1'b0;
                            2'b11:   pin_q <= 1'b1;
                            default: pin_q <= pin_q;
                        endcase
                    end
                end
                CH_PWM: begin
                    if (duty0)        pin_q <= ~active;
                    else if (duty100) pin_q <= active;
                    else if (ovf)     pin_q <= active;
                    else if (match)   pin_q <= ~active;
                end
                default: pin_q <= pin_q;
            endcase
        end
    end

    p_cmp_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == CH_COMPARE && !match) |=> $stable(pin_q));

    p_pwm_ovf_active_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == CH_PWM && ovf && !duty0) |=> (pin_q == $past(active)));

    p_pwm_duty0_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == CH_PWM && duty0) |=> (pin_q == !$past(active)));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic [CNT_W-1:0] cnt_mod,
    input  logic             pin_in,
    input  logic             csr_rd,
    input  logic             csr_wr,
    input  logic [7:0]       csr_wdata,
    output logic [7:0]       csr_rdata,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    output logic [CNT_W-1:0] val_rdata,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq
);
    ch_ctrl_t         ctrl_q;
    ch_mode_e         mode;
    logic [CNT_W-1:0] val_q;
    logic             cap_hit;
    logic             match;
    logic             duty0;
    logic             duty100;
    logic             evt;
    logic             flag;
    logic             pin_q;

    assign mode = decode_mode(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= '0;
        else if (csr_wr) ctrl_q <= unpack_ctrl(csr_wdata);
    end

    // capture has priority over a software write in the same cycle
    always_ff @(posedge clk) begin
        if (rst)          val_q <= '0;
        else if (cap_hit) val_q <= cnt_val;
        else if (val_wr)  val_q <= val_wdata;
    end

    tmr_chan_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .enable   (mode == CH_CAPTURE),
        .edge_sel (ctrl_q.edge_sel),
        .hit      (cap_hit)
    );

    assign match   = (cnt_val == val_q);
    assign duty0   = (val_q == '0);
    assign duty100 = (val_q > cnt_mod);

    assign evt = cap_hit
               | ((mode == CH_COMPARE) & match)
               | ((mode == CH_PWM) & match & ~duty0 & ~duty100);

    tmr_chan_flag u_flag (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .st_rd       (csr_rd),
        .st_wr       (csr_wr),
        .wr_flag_bit (csr_wdata[FLAG_BIT]),
        .flag        (flag)
    );

    tmr_chan_out u_out (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .edge_sel (ctrl_q.edge_sel),
        .match    (match),
        .ovf      (cnt_ovf),
        .duty0    (duty0),
        .duty100  (duty100),
        .pin_q    (pin_q)
    );

    assign csr_rdata = pack_status(flag, ctrl_q);
    assign val_rdata = val_q;
    assign pin_out   = pin_q;
    assign pin_oe    = (mode == CH_COMPARE) || (mode == CH_PWM);
    assign irq       = flag & ctrl_q.irq_en;

    p_capture_latch_r3: assert property (@(posedge clk) disable iff (rst)
        cap_hit |=> (val_q == $past(cnt_val)));

    p_off_no_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == CH_OFF && !flag) |=> !flag);

    p_pwm_extreme_noflag_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == CH_PWM && (duty0 || duty100) && !flag) |=> !flag);

    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (csr_rdata[FLAG_BIT] && csr_rdata[6]));

endmodule

// File: tb/tmr_chan_test.sv
`timescale 1ns/1ps
module tmr_chan_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_ovf;
    logic [CNT_W-1:0] cnt_mod;
    logic             pin_in;
    logic             csr_rd;
    logic             csr_wr;
    logic [7:0]       csr_wdata;
    logic [7:0]       csr_rdata;
    logic             val_wr;
    logic [CNT_W-1:0] val_wdata;
    logic [CNT_W-1:0] val_rdata;
    logic             pin_out;
    logic             pin_oe;
    logic             irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    tmr_chan #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .cnt_mod(cnt_mod),
        .pin_in(pin_in), .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .val_wr(val_wr), .val_wdata(val_wdata),
        .val_rdata(val_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {write byte, expected read byte, expected pin_oe}
    localparam logic [16:0] VEC [8] = '{
        {8'h00, 8'h00, 1'b0},
        {8'h30, 8'h30, 1'b0},
        {8'h04, 8'h04, 1'b0},
        {8'h0F, 8'h0C, 1'b0},
        {8'h14, 8'h14, 1'b1},
        {8'h5C, 8'h5C, 1'b1},
        {8'h28, 8'h28, 1'b1},
        {8'hA4, 8'h24, 1'b1}
    };

    task automatic step(); @(negedge clk); endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic csr_write(logic [7:0] b);
        csr_wr = 1'b1; csr_wdata = b; step(); csr_wr = 1'b0;
    endtask

    task automatic csr_read();
        csr_rd = 1'b1; step(); csr_rd = 1'b0;
    endtask

    task automatic val_write(logic [CNT_W-1:0] v);
        val_wr = 1'b1; val_wdata = v; step(); val_wr = 1'b0;
    endtask

    task automatic cmp_hit(logic [CNT_W-1:0] v);
        cnt_val = v; step(); cnt_val = 16'hFFFF;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cnt_val = 16'hFFFF; cnt_ovf = 1'b0; cnt_mod = 16'd9; pin_in = 1'b0;
        csr_rd = 1'b0; csr_wr = 1'b0; csr_wdata = 8'h00; val_wr = 1'b0; val_wdata = '0;
        repeat (3) step();
        chk("R11 status", csr_rdata, 8'h00);
        chk("R11 value", val_rdata, 0);
        chk("R11 pin_out", pin_out, 0);
        chk("R11 pin_oe", pin_oe, 0);
        chk("R11 irq", irq, 0);
        rst = 1'b0;
        step();

        // R1 R2 R12: status byte decode table
        for (int i = 0; i < 8; i++) begin
            csr_write(VEC[i][16:9]);
            chk("R1 readback", csr_rdata, VEC[i][8:1]);
            chk("R12 pin_oe", pin_oe, VEC[i][0]);
        end
        csr_write(8'h00);
        val_write(16'd5);
        chk("R1 value readback", val_rdata, 16'd5);

        // R2: off channel ignores a match
        csr_write(8'h10);
        cnt_val = 16'd5; step(); step(); cnt_val = 16'hFFFF;
        chk("R2 no flag when off", csr_rdata[7], 0);
        chk("R2 pin_oe off", pin_oe, 0);

        // R4: compare actions
        csr_write(8'h1C);
        cmp_hit(16'd5);
        chk("R4 set on match", pin_out, 1);
        chk("R4 flag on match", csr_rdata[7], 1);
        csr_write(8'h18);
        cmp_hit(16'd5);
        chk("R4 clear on match", pin_out, 0);
        csr_write(8'h14);
        cmp_hit(16'd5);
        chk("R4 toggle on match", pin_out, 1);
        step();
        chk("R4 hold without match", pin_out, 1);
        cmp_hit(16'd5);
        chk("R4 toggle again", pin_out, 0);

        // R7: interrupt request
        csr_write(8'h54);
        chk("R7 irq with enable", irq, 1);
        csr_write(8'h14);
        chk("R7 irq masked", irq, 0);

        // R8 R10: clearing handshake
        csr_write(8'h14);
        chk("R8 write without read keeps flag", csr_rdata[7], 1);
        csr_read();
        csr_write(8'h94);
        chk("R8 writing one has no effect", csr_rdata[7], 1);
        csr_write(8'h14);
        chk("R10 write disarms clear", csr_rdata[7], 1);
        csr_read();
        step();
        csr_write(8'h14);
        chk("R8 read then zero write clears", csr_rdata[7], 0);

        // R9: event between arming read and clearing write
        cmp_hit(16'd5);
        chk("R9 flag set", csr_rdata[7], 1);
        csr_read();
        cmp_hit(16'd5);
        csr_write(8'h14);
        chk("R9 mid-sequence event kept", csr_rdata[7], 1);
        csr_read();
        csr_write(8'h14);
        chk("R8 clear after retry", csr_rdata[7], 0);

        // R3: capture, rising only
        cnt_val = 16'h1234;
        csr_write(8'h04);
        chk("R12 capture no oe", pin_oe, 0);
        pin_in = 1'b1;
        step(); step();
        chk("R3 latency not yet", csr_rdata[7], 0);
        step();
        chk("R3 rising flag", csr_rdata[7], 1);
        chk("R3 rising value", val_rdata, 16'h1234);
        csr_read(); csr_write(8'h04);
        pin_in = 1'b0;
        repeat (4) step();
        chk("R3 falling ignored in rising mode", csr_rdata[7], 0);

        // falling only
        csr_write(8'h08);
        cnt_val = 16'h0777;
        pin_in = 1'b1;
        repeat (4) step();
        chk("R3 rising ignored in falling mode", csr_rdata[7], 0);
        pin_in = 1'b0;
        repeat (3) step();
        chk("R3 falling flag", csr_rdata[7], 1);
        chk("R3 falling value", val_rdata, 16'h0777);
        csr_read(); csr_write(8'h08);

        // both edges
        csr_write(8'h0C);
        cnt_val = 16'h0ABC;
        pin_in = 1'b1;
        repeat (3) step();
        chk("R3 both rising value", val_rdata, 16'h0ABC);
        csr_read(); csr_write(8'h0C);
        cnt_val = 16'h0DEF;
        pin_in = 1'b0;
        repeat (3) step();
        chk("R3 both falling flag", csr_rdata[7], 1);
        chk("R3 both falling value", val_rdata, 16'h0DEF);
        csr_read(); csr_write(8'h0C);

        // R5: PWM high-true
        cnt_val = 16'd8;
        val_write(16'd3);
        csr_write(8'h28);
        cnt_val = 16'd9; cnt_ovf = 1'b1; step();
        cnt_ovf = 1'b0; cnt_val = 16'd0;
        chk("R5 high-true active after overflow", pin_out, 1);
        step();
        chk("R5 stays active", pin_out, 1);
        cnt_val = 16'd3; step();
        cnt_val = 16'd4;
        chk("R5 inactive after match", pin_out, 0);
        chk("R5 flag on match", csr_rdata[7], 1);
        step();
        chk("R5 stays inactive", pin_out, 0);
        csr_read(); csr_write(8'h28);

        // low-true
        csr_write(8'h24);
        cnt_val = 16'd9; cnt_ovf = 1'b1; step();
        cnt_ovf = 1'b0; cnt_val = 16'd0;
        chk("R5 low-true active after overflow", pin_out, 0);
        cnt_val = 16'd3; step();
        cnt_val = 16'd0;
        chk("R5 low-true inactive after match", pin_out, 1);
        val_write(16'd9);
        cnt_val = 16'd9; cnt_ovf = 1'b1; step();
        cnt_ovf = 1'b0; cnt_val = 16'd0;
        chk("R5 overflow beats match", pin_out, 0);
        csr_read(); csr_write(8'h24);

        // R6: 0% and 100% duty
        val_write(16'd0);
        step();
        chk("R6 zero duty inactive", pin_out, 1);
        chk("R6 zero duty no flag", csr_rdata[7], 0);
        cnt_val = 16'd9; cnt_ovf = 1'b1; step();
        cnt_ovf = 1'b0; cnt_val = 16'd0;
        chk("R6 zero duty ignores overflow", pin_out, 1);
        csr_write(8'h28);
        step();
        chk("R6 zero duty high-true inactive", pin_out, 0);
        val_write(16'd10);
        cnt_val = 16'd10; step();
        cnt_val = 16'd0;
        chk("R6 full duty active", pin_out, 1);
        chk("R6 full duty no flag", csr_rdata[7], 0);

        done = 1;
        report();
        $finish;
    end
endmodule